// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port (SPI Master/Slave)

This block is a byte-oriented SPI controller that a processor drives through three registers on a small parallel bus: control, status and data. In master mode a write to the data register launches one byte transfer. The block divides the system clock to produce SCK and shifts the byte out on MOSI while it gathers a byte from MISO. In slave mode an external master supplies SCK and enables the unit by pulling the active-low select input low. The slave then shifts its loaded byte out on MISO and collects the byte arriving on MOSI.

Each finished byte sets a completion flag and copies the received byte into a read buffer. Writing the data register while a byte is still moving sets a collision flag, and the byte in flight is not disturbed. An interrupt request is raised only when the block's own interrupt enable and an external serial-port enable are both set. Clock polarity, clock phase, bit order and one of four master bit rates are chosen in the control register.

Top module: `spi_port_ctrl`

## Requirements
- R1: After the synchronous reset, the control register, both status flags, the read buffer, the read data and `irq_o` are zero, and `sck_o` is low.
- R2: Register map on `bus_addr_i`: 0 is control, 1 is status, 2 is data. The control bits, from bit 7 to bit 0, are: interrupt enable, port enable, LSB-first, master, CPOL, CPHA, rate[1:0]. Control reads back exactly as written. With port enable and master both set, a data write while idle starts a transfer in which `sck_o` makes exactly 16 transitions.
- R3: At the end of a master byte, status bit 7 (complete) reads 1 and `sck_o` is back at the level given by CPOL.
- R4: `irq_o` is high one cycle after the complete flag, the interrupt enable bit and `ser_irq_en_i` are all 1. It goes low one cycle after any of them drops.
- R5: In slave mode, while `ssn_i` is high, toggling `sck_i` and `mosi_i` sets no flag, leaves the read buffer unchanged and holds `miso_o` low.
- R6: CPOL sets the idle SCK level. With CPHA=0, data is sampled on the first (leading) SCK edge and changes on the trailing edge, and the first bit is already on the line before the first edge. With CPHA=1, data changes on the leading edge and is sampled on the trailing edge. All four modes work in both master and slave mode.
- R7: LSB-first=1 shifts bit 0 first. LSB-first=0 shifts bit 7 first. The same order applies to the transmitted and the received byte.
- R8: Master SCK holds each level for 2, 8, 32 or 64 system clocks when rate is 00, 01, 10 or 11, which divides the clock by 4, 16, 64 or 128.
- R9: A data write during a transfer sets status bit 6 (collision). The byte being shifted out is unchanged and the transfer is not restarted.
- R10: Both flags are cleared by a status read that sees either flag set, followed by a read or write of the data register. A data access without that prior status read clears nothing.
- R11: A data read returns the byte buffered at the end of the last completed transfer, never the live shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered one cycle after the read strobe |
| ser_irq_en_i | input | 1 | External serial-port interrupt enable |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave, low when not selected) |
| ssn_i | input | 1 | Active-low slave select |

## Verification
Master transfers run with MISO looped back inverted from MOSI. A monitor records the MOSI bits at the sampling edge of the active mode, so the bit order (R7), the edge choice (R6) and the inverted received byte (R11) are judged separately. The same monitor measures every SCK half period against the selected rate (R8) and counts SCK edges (R2). Slave transfers are bit-banged in all four modes with both bit orders, capturing MISO at the edge the mode defines, so that a wrong phase or order shows up as a different byte. Random bytes, modes and rates are mixed with directed cases: a write in mid-transfer, a data read without the arming status read, the interrupt gates toggled one at a time, and select held high.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef struct packed {
    logic       ien;
    logic       en;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [1:0] rate_i,
  output logic       running_o,
  output logic       edge_o,
  output logic       phase_o
);
  localparam int CNT_W = $clog2(BASE_DIV * 16) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_lim;

  always_comb begin
    case (rate_i)
      2'd0:    half_lim = CNT_W'(BASE_DIV / 2);
      2'd1:    half_lim = CNT_W'(BASE_DIV * 2);
      2'd2:    half_lim = CNT_W'(BASE_DIV * 8);
      default: half_lim = CNT_W'(BASE_DIV * 16);
    endcase
  end

  assign edge_o = running_o && (cnt_q == half_lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      running_o <= 1'b0;
      cnt_q     <= '0;
      phase_o   <= 1'b0;
    end else if (start_i) begin
      running_o <= 1'b1;
      cnt_q     <= '0;
      phase_o   <= 1'b0;
    end else if (running_o) begin
      if (edge_o) begin
        cnt_q   <= '0;
        phase_o <= ~phase_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (stop_i) running_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         lsb_first_i,
  input  logic         cpha_i,
  input  logic         edge_i,
  input  logic         sin_i,
  output logic         sout_o,
  output logic         done_o,
  output logic [W-1:0] rx_fin_o,
  output logic         mid_o
);
  localparam int IDX_W = $clog2(2 * W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(2 * W - 1);

  logic [W-1:0]     sh_q, rx_q, rx_shift, sh_shift;
  logic [IDX_W-1:0] idx_q;
  logic             lead, samp, adv, act;

  assign lead     = ~idx_q[0];
  assign samp     = cpha_i ? ~lead : lead;
  assign adv      = cpha_i ? (lead && idx_q != '0) : ~lead;
  assign act      = edge_i && !clr_i;
  assign rx_shift = lsb_first_i ? {sin_i, rx_q[W-1:1]} : {rx_q[W-2:0], sin_i};
  assign sh_shift = lsb_first_i ? {1'b0, sh_q[W-1:1]} : {sh_q[W-2:0], 1'b0};
  assign sout_o   = lsb_first_i ? sh_q[0] : sh_q[W-1];
  assign done_o   = act && (idx_q == LAST);
  assign rx_fin_o = samp ? rx_shift : rx_q;
  assign mid_o    = (idx_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      rx_q  <= '0;
      idx_q <= '0;
    end else begin
      if (load_i) sh_q <= load_data_i;
      else if (act && adv) sh_q <= sh_shift;
      if (act && samp) rx_q <= rx_shift;
      if (clr_i) idx_q <= '0;
      else if (edge_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BASE_DIV = 4,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ser_irq_en_i,
  output logic              irq_o,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              miso_o,
  input  logic              ssn_i
);
  ctrl_t             ctrl_q;
  logic              spif_q, wcol_q, armed_q;
  logic [DATA_W-1:0] rbuf_q;
  logic              sck_s, mosi_s, ssn_s, sck_prev_q;
  logic              m_run, m_edge, m_phase;
  logic              core_sout, core_done, core_mid, core_clr, core_edge, core_sin;
  logic [DATA_W-1:0] core_rx;
  logic              wr_ctrl, wr_data, rd_stat, rd_data, busy, start, load, s_edge;

  spi_sync #(.N(3), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sck_i, mosi_i, ssn_i}),
    .q_o ({sck_s, mosi_s, ssn_s})
  );

  spi_rate_gen #(.BASE_DIV(BASE_DIV)) u_rate (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .stop_i    (core_done),
    .rate_i    (ctrl_q.rate),
    .running_o (m_run),
    .edge_o    (m_edge),
    .phase_o   (m_phase)
  );

  spi_shift_core #(.W(DATA_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (core_clr),
    .load_i      (load),
    .load_data_i (bus_wdata_i),
    .lsb_first_i (ctrl_q.lsb_first),
    .cpha_i      (ctrl_q.cpha),
    .edge_i      (core_edge),
    .sin_i       (core_sin),
    .sout_o      (core_sout),
    .done_o      (core_done),
    .rx_fin_o    (core_rx),
    .mid_o       (core_mid)
  );

  assign wr_ctrl   = bus_wr_i && bus_addr_i == ADDR_CTRL;
  assign wr_data   = bus_wr_i && bus_addr_i == ADDR_DATA;
  assign rd_stat   = bus_rd_i && bus_addr_i == ADDR_STAT;
  assign rd_data   = bus_rd_i && bus_addr_i == ADDR_DATA;
  assign busy      = ctrl_q.master ? m_run : core_mid;
  assign load      = wr_data && !busy;
  assign start     = load && ctrl_q.en && ctrl_q.master;
  assign s_edge    = (sck_s != sck_prev_q);
  assign core_clr  = !ctrl_q.en || (ctrl_q.master ? start : ssn_s);
  assign core_edge = ctrl_q.master ? m_edge : s_edge;
  assign core_sin  = ctrl_q.master ? miso_i : mosi_s;

  assign sck_o  = ctrl_q.cpol ^ m_phase;
  assign mosi_o = (ctrl_q.en && ctrl_q.master) ? core_sout : 1'b0;
  assign miso_o = (ctrl_q.en && !ctrl_q.master && !ssn_s) ? core_sout : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      spif_q      <= 1'b0;
      wcol_q      <= 1'b0;
      armed_q     <= 1'b0;
      rbuf_q      <= '0;
      irq_o       <= 1'b0;
      bus_rdata_o <= '0;
      sck_prev_q  <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[7:0]);
      if (rd_stat && (spif_q || wcol_q)) armed_q <= 1'b1;
      if ((wr_data || rd_data) && armed_q) begin
        spif_q  <= 1'b0;
        wcol_q  <= 1'b0;
        armed_q <= 1'b0;
      end
      if (core_done) begin
        spif_q <= 1'b1;
        rbuf_q <= core_rx;
      end
      if (wr_data && busy) wcol_q <= 1'b1;
      irq_o <= ctrl_q.ien && ser_irq_en_i && spif_q;
      if (bus_rd_i) begin
        case (bus_addr_i)
          ADDR_CTRL: bus_rdata_o <= DATA_W'(ctrl_q);
          ADDR_STAT: bus_rdata_o <= {spif_q, wcol_q, {(DATA_W-2){1'b0}}};
          ADDR_DATA: bus_rdata_o <= rbuf_q;
          default:   bus_rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int BASE_DIV = 4
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] ctrl_q,
  input logic       spif_q,
  input logic       wcol_q,
  input logic       irq_o,
  input logic       ser_irq_en_i,
  input logic       sck_o,
  input logic       m_run,
  input logic       busy,
  input logic       wr_data,
  input logic       ssn_s,
  input logic       core_done
);
  localparam int CK_W = $clog2(BASE_DIV * 16) + 2;

  logic [CK_W-1:0] ck_cnt;
  logic            ck_prev;
  logic [CK_W-1:0] ck_half;

  always_comb begin
    case (ctrl_q[1:0])
      2'd0:    ck_half = CK_W'(BASE_DIV / 2);
      2'd1:    ck_half = CK_W'(BASE_DIV * 2);
      2'd2:    ck_half = CK_W'(BASE_DIV * 8);
      default: ck_half = CK_W'(BASE_DIV * 16);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_cnt  <= '0;
      ck_prev <= 1'b0;
    end else begin
      ck_prev <= sck_o;
      if (!m_run) ck_cnt <= '0;
      else if (sck_o != ck_prev) ck_cnt <= CK_W'(1);
      else ck_cnt <= ck_cnt + 1'b1;
    end
  end

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (ctrl_q == 8'h00 && !spif_q && !wcol_q && !irq_o)); // R1

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    ($rose(spif_q) && ctrl_q[4]) |-> (sck_o == ctrl_q[3])); // R3

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(spif_q && ser_irq_en_i && ctrl_q[7])); // R4

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[4] && ssn_s) |-> !core_done); // R5

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[4] && $past(m_run) && sck_o != ck_prev) |-> (ck_cnt == ck_half)); // R8

  AST_COLLISION: assert property (@(posedge clk) disable iff (rst)
    (wr_data && busy) |=> wcol_q); // R9
endmodule

bind spi_port_ctrl spi_port_chk #(.BASE_DIV(BASE_DIV)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ctrl_q       (ctrl_q),
  .spif_q       (spif_q),
  .wcol_q       (wcol_q),
  .irq_o        (irq_o),
  .ser_irq_en_i (ser_irq_en_i),
  .sck_o        (sck_o),
  .m_run        (m_run),
  .busy         (busy),
  .wr_data      (wr_data),
  .ssn_s        (ssn_s),
  .core_done    (core_done)
);

// File: tb/sim_spi_port_ctrl.sv
`timescale 1ns/1ps
module sim_spi_port_ctrl;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  logic ser_en = 1'b0, irq;
  logic b_sck = 1'b0, b_mosi = 1'b0, b_ssn = 1'b1;
  logic sck_o, mosi_o, miso_i, miso_o;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;
  logic [7:0] last_rx = 8'h00;

  // monitor state
  int epoch = 0, ep_seen = -1, ep_cnt = 0, last_edge = 0, mon_bad = 0, mon_h = 2;
  logic mcpha = 1'b0, mon_prev = 1'b0;
  logic [7:0] mon_cap = 8'h00;

  always #2 clk = ~clk;

  assign miso_i = ~mosi_o;

  spi_port_ctrl u0 (
    .clk (clk), .rst (rst),
    .bus_wr_i (bus_wr), .bus_rd_i (bus_rd), .bus_addr_i (bus_addr),
    .bus_wdata_i (bus_wdata), .bus_rdata_o (bus_rdata),
    .ser_irq_en_i (ser_en), .irq_o (irq),
    .sck_i (b_sck), .sck_o (sck_o),
    .mosi_i (b_mosi), .mosi_o (mosi_o),
    .miso_i (miso_i), .miso_o (miso_o),
    .ssn_i (b_ssn)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && sck_o != mon_prev) begin
      if (ep_seen != epoch) begin
        ep_seen = epoch;
        ep_cnt = 1;
      end else begin
        ep_cnt = ep_cnt + 1;
        if (cyc - last_edge != mon_h) mon_bad = mon_bad + 1;
      end
      last_edge = cyc;
      if ((ep_cnt % 2 == 1) != mcpha) mon_cap = {mon_cap[6:0], mosi_o};
    end
    mon_prev = sck_o;
  end

  function automatic logic [7:0] f_rev(input logic [7:0] b);
    for (int i = 0; i < 8; i++) f_rev[i] = b[7-i];
  endfunction

  function automatic int f_half(input logic [1:0] r);
    case (r)
      2'd0: f_half = 2;
      2'd1: f_half = 8;
      2'd2: f_half = 32;
      default: f_half = 64;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr_t(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_rd_t(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic poll_done(output logic [7:0] v);
    v = 8'h00;
    for (int k = 0; k < 4000 && !v[7]; k++) bus_rd_t(A_STAT, v);
  endtask

  task automatic m_xfer(input logic cpol, input logic cpha, input logic dord,
                        input logic [1:0] rate, input logic [7:0] tx);
    logic [7:0] v;
    int bad0;
    bus_wr_t(A_CTRL, {1'b0, 1'b1, dord, 1'b1, cpol, cpha, rate});
    mcpha = cpha; mon_h = f_half(rate);
    repeat (2) @(negedge clk);
    bad0 = mon_bad; epoch++;
    bus_wr_t(A_DATA, tx);
    poll_done(v);
    chk(v == 8'h80, "R3 status complete", v, 8'h80);
    chk(sck_o == cpol, "R3 sck idle level", sck_o, cpol);
    chk(ep_cnt == 16, "R2 sck edge count", ep_cnt, 16);
    chk(mon_bad == bad0, "R8 half period", mon_bad - bad0, 0);
    chk(mon_cap == (dord ? f_rev(tx) : tx), "R6 R7 mosi stream", mon_cap,
        dord ? f_rev(tx) : tx);
    bus_rd_t(A_DATA, v);
    chk(v == ~tx, "R11 received byte", v, ~tx);
    last_rx = ~tx;
    bus_rd_t(A_STAT, v);
    chk(v == 8'h00, "R10 flags cleared", v, 0);
  endtask

  task automatic s_xfer(input logic cpol, input logic cpha, input logic dord,
                        input logic [7:0] d, input logic [7:0] m);
    logic [7:0] v, cap;
    logic bt;
    cap = 8'h00;
    bus_wr_t(A_CTRL, {1'b0, 1'b1, dord, 1'b0, cpol, cpha, 2'b00});
    @(negedge clk); b_sck = cpol;
    bus_wr_t(A_DATA, d);
    @(negedge clk); b_ssn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      bt = dord ? m[i] : m[7-i];
      if (!cpha) begin
        b_mosi = bt;
        repeat (8) @(negedge clk);
        cap = dord ? {miso_o, cap[7:1]} : {cap[6:0], miso_o};
        b_sck = ~cpol;
        repeat (8) @(negedge clk);
        b_sck = cpol;
      end else begin
        b_sck = ~cpol; b_mosi = bt;
        repeat (8) @(negedge clk);
        cap = dord ? {miso_o, cap[7:1]} : {cap[6:0], miso_o};
        b_sck = cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    b_ssn = 1'b1;
    repeat (4) @(negedge clk);
    chk(cap == d, "R6 R7 slave miso stream", cap, d);
    poll_done(v);
    chk(v == 8'h80, "R6 slave complete", v, 8'h80);
    bus_rd_t(A_DATA, v);
    chk(v == m, "R7 R11 slave received byte", v, m);
    last_rx = m;
    bus_rd_t(A_STAT, v);
    chk(v == 8'h00, "R10 slave flags cleared", v, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, w;
    int seed;
    seed = $urandom(32'd2024);
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk(sck_o == 1'b0, "R1 sck after reset", sck_o, 0);
    bus_rd_t(A_CTRL, v); chk(v == 8'h00, "R1 control reset", v, 0);
    bus_rd_t(A_STAT, v); chk(v == 8'h00, "R1 status reset", v, 0);
    bus_rd_t(A_DATA, v); chk(v == 8'h00, "R1 buffer reset", v, 0);
    // R2 control readback
    bus_wr_t(A_CTRL, 8'h2D); bus_rd_t(A_CTRL, v);
    chk(v == 8'h2D, "R2 control readback", v, 8'h2D);

    // directed master: every mode, both orders, every rate
    for (int md = 0; md < 4; md++)
      for (int od = 0; od < 2; od++)
        m_xfer(md[1], md[0], od[0], 2'(md), 8'hB4 ^ 8'(md * 17 + od));
    m_xfer(1'b0, 1'b0, 1'b0, 2'd3, 8'h01);
    m_xfer(1'b1, 1'b1, 1'b1, 2'd0, 8'h80);

    // R9 write collision during a transfer
    bus_wr_t(A_CTRL, 8'h52);
    mcpha = 1'b0; mon_h = 32;
    repeat (2) @(negedge clk);
    epoch++;
    bus_wr_t(A_DATA, 8'hA5);
    repeat (100) @(negedge clk);
    bus_wr_t(A_DATA, 8'h3C);
    poll_done(v);
    chk(v == 8'hC0, "R9 collision flag", v, 8'hC0);
    chk(mon_cap == 8'hA5, "R9 byte unchanged", mon_cap, 8'hA5);
    chk(ep_cnt == 16, "R9 no restart", ep_cnt, 16);
    bus_rd_t(A_DATA, v); chk(v == 8'h5A, "R11 buffer after collision", v, 8'h5A);
    bus_rd_t(A_STAT, v); chk(v == 8'h00, "R10 clear after collision", v, 0);

    // R10 data access without arming status read clears nothing
    bus_wr_t(A_CTRL, 8'h50);
    mon_h = 2;
    repeat (2) @(negedge clk);
    epoch++;
    bus_wr_t(A_DATA, 8'h96);
    repeat (60) @(negedge clk);
    bus_rd_t(A_DATA, v); chk(v == 8'h69, "R11 buffer read", v, 8'h69);
    bus_rd_t(A_STAT, v); chk(v == 8'h80, "R10 flag kept", v, 8'h80);
    bus_rd_t(A_DATA, v);
    bus_rd_t(A_STAT, v); chk(v == 8'h00, "R10 flag cleared", v, 0);

    // R4 interrupt gating
    ser_en = 1'b1;
    bus_wr_t(A_CTRL, 8'h50);
    bus_wr_t(A_DATA, 8'h11);
    poll_done(v);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R4 irq off without enable", irq, 0);
    bus_wr_t(A_CTRL, 8'hD0);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R4 irq raised", irq, 1);
    ser_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R4 irq gated by port enable", irq, 0);
    ser_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R4 irq back", irq, 1);
    bus_rd_t(A_DATA, v);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R4 irq drops with flag", irq, 0);
    last_rx = 8'hEE;
    ser_en = 1'b0;

    // directed slave: every mode, both orders
    for (int md = 0; md < 4; md++)
      for (int od = 0; od < 2; od++)
        s_xfer(md[1], md[0], od[0], 8'hC3 ^ 8'(md * 5 + od), 8'h2E ^ 8'(md * 29 + od * 3));

    // R5 slave not selected
    bus_wr_t(A_CTRL, 8'h40);
    b_ssn = 1'b1; b_sck = 1'b0;
    w = 8'h00;
    for (int i = 0; i < 16; i++) begin
      repeat (6) @(negedge clk);
      b_sck = ~b_sck; b_mosi = $urandom_range(0, 1);
      if (miso_o) w = w + 1;
    end
    repeat (8) @(negedge clk);
    chk(w == 8'h00, "R5 miso held low", w, 0);
    bus_rd_t(A_STAT, v); chk(v == 8'h00, "R5 no flag", v, 0);
    bus_rd_t(A_DATA, v); chk(v == last_rx, "R5 buffer unchanged", v, last_rx);

    // random master and slave transfers
    for (int n = 0; n < 20; n++) begin
      v = 8'($urandom);
      m_xfer(v[0], v[1], v[2], v[4:3], 8'($urandom));
    end
    for (int n = 0; n < 8; n++) begin
      v = 8'($urandom);
      s_xfer(v[0], v[1], v[2], 8'($urandom), 8'($urandom));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule